// File: doc/BRIEF.md
# Pulsed Time-of-Flight Range Sweep Controller

This block runs one measurement of a pulsed laser rangefinder. A start request begins a burst of short laser trigger pulses, one per repetition period. Each shot opens a receiver sample gate. The gate's delay after the shot grows by one range bin from one shot to the next, so the burst steps from the nearest bin out to the farthest. No echo is timed directly. Instead, the block learns which bins hold a reflector by checking, shot after shot, whether the synchronised detector comparator is high while the gate is open.

When the last shot's period ends, the block reports the lowest-numbered bin that saw a response. If no bin saw one, it raises a no-target flag. A one-cycle valid strobe marks the result. All timing is counted on one fast clock. At 150 MHz one tick equals one metre of range (about 6.67 ns of round trip). With the default parameters, 500 shots are spaced 180000 ticks apart (1.2 ms), which gives a measurement of about 600 ms. The laser trigger lasts 3 ticks (about 20 ns).

Top module: `tof_range_sweep`

## Requirements
- R1: After reset, laser_trig, gate_strobe, result_valid and no_target are 0 and range_bin is 0.
- R2: A start sampled high while idle begins a sweep. laser_trig is high for PULSE_W cycles at the beginning of each of NUM_BINS consecutive periods of SHOT_PERIOD cycles. The first of these begins in the cycle after the edge that sampled start.
- R3: In shot n (counted from 0), gate_strobe is high for TICKS_PER_BIN cycles. It begins GATE_BASE + n*TICKS_PER_BIN cycles after that shot's trigger begins. It never overlaps laser_trig, and it closes at least one cycle before the next shot.
- R4: det_in passes through a two-stage synchroniser. A level applied to det_in during cycle t counts as a response if gate_strobe is high in cycle t+2.
- R5: range_bin reports the lowest shot index whose gate saw a response. Responses in later bins do not change it.
- R6: If no gate saw a response during the sweep, no_target is 1 and range_bin is 0. Otherwise no_target is 0.
- R7: result_valid is high for exactly one cycle, NUM_BINS*SHOT_PERIOD cycles after the edge that sampled start. range_bin and no_target hold their values until the next result.
- R8: A start request during a sweep is ignored. It neither restarts nor shifts the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; one tick per TICKS_PER_BIN fraction of a bin |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Measurement request, accepted only when idle |
| det_in | input | 1 | Asynchronous detector comparator output |
| laser_trig | output | 1 | Laser fire pulse |
| gate_strobe | output | 1 | Receiver sample gate |
| range_bin | output | $clog2(NUM_BINS) | Nearest occupied bin |
| no_target | output | 1 | No bin was occupied |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
On every cycle, the embedded assertions check the following: the trigger and the gate never overlap; a sweep, once started, runs forward without restarting; the first captured bin is never overwritten; the valid strobe lasts one cycle; and a no-target result carries bin 0. Other properties can only be shown by the bench's scenarios, because they depend on where an echo falls in time. These are that the gate delay advances by exactly one bin per shot, that the two-cycle synchroniser delay moves an echo into the bin it lands in, and that the nearest of several occupied bins is the one reported. The scenarios also cover echoes outside every gate and a start request repeated mid-sweep.

// File: rtl/tof_pkg.sv
package tof_pkg;
  // Tick (relative to shot launch) at which the gate of a given shot opens.
  function automatic int unsigned gate_open_at(input int unsigned shot,
                                               input int unsigned base,
                                               input int unsigned tpb);
    return base + shot * tpb;
  endfunction

  // True when a tick falls inside the gate window of the given shot.
  function automatic logic in_gate(input int unsigned tick,
                                   input int unsigned shot,
                                   input int unsigned base,
                                   input int unsigned tpb);
    int unsigned lo;
    lo = gate_open_at(shot, base, tpb);
    return (tick >= lo) && (tick < lo + tpb);
  endfunction
endpackage

// File: rtl/tof_sync.sv
module tof_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/tof_shot_timer.sv
module tof_shot_timer #(
  parameter int NUM_BINS      = 500,
  parameter int SHOT_PERIOD   = 180000,
  parameter int PULSE_W       = 3,
  parameter int GATE_BASE     = 4,
  parameter int TICKS_PER_BIN = 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  output logic                                  running,
  output logic [$clog2(NUM_BINS)-1:0]           shot,
  output logic                                  launch,
  output logic                                  sweep_done,
  output logic                                  laser_trig,
  output logic                                  gate_strobe
);
  localparam int TICK_W = $clog2(SHOT_PERIOD);
  localparam int BIN_W  = $clog2(NUM_BINS);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SHOT_PERIOD - 1);
  localparam logic [BIN_W-1:0]  LAST_SHOT = BIN_W'(NUM_BINS - 1);

  generate
    if (GATE_BASE + NUM_BINS * TICKS_PER_BIN >= SHOT_PERIOD) begin : g_bad_span
      $error("last gate must close before the next shot");
    end
    if (GATE_BASE < PULSE_W) begin : g_bad_base
      $error("gate must open after the trigger pulse ends");
    end
  endgenerate

  logic [TICK_W-1:0] tick;
  logic              period_end;

  assign period_end = running && (tick == LAST_TICK);
  assign sweep_done = period_end && (shot == LAST_SHOT);
  assign launch     = !running && start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      tick    <= '0;
      shot    <= '0;
    end else if (launch) begin
      running <= 1'b1;
      tick    <= '0;
      shot    <= '0;
    end else if (running) begin
      if (period_end) begin
        tick <= '0;
        if (sweep_done) running <= 1'b0;
        else            shot    <= shot + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign laser_trig  = running && (32'(tick) < PULSE_W);
  assign gate_strobe = running &&
                       tof_pkg::in_gate(32'(tick), 32'(shot), GATE_BASE, TICKS_PER_BIN);

  assert_sweep_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sweep_done) |=> (running && shot >= $past(shot)));

  assert_gate_clear_of_laser_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(laser_trig && gate_strobe));

  assert_gate_shut_at_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> !gate_strobe);
endmodule

// File: rtl/tof_hit_record.sv
module tof_hit_record #(
  parameter int NUM_BINS = 500
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        sample_hit,
  input  logic [$clog2(NUM_BINS)-1:0] shot,
  input  logic                        sweep_done,
  output logic [$clog2(NUM_BINS)-1:0] range_bin,
  output logic                        no_target,
  output logic                        result_valid
);
  localparam int BIN_W = $clog2(NUM_BINS);

  logic             found;
  logic [BIN_W-1:0] best;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found <= 1'b0;
      best  <= '0;
    end else if (clear) begin
      found <= 1'b0;
      best  <= '0;
    end else if (sample_hit && !found) begin
      found <= 1'b1;
      best  <= shot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_bin    <= '0;
      no_target    <= 1'b0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= sweep_done;
      if (sweep_done) begin
        range_bin <= found ? best : '0;
        no_target <= !found;
      end
    end
  end

  assert_first_hit_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (found && !clear) |=> (found && best == $past(best)));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_empty_reports_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && no_target) |-> (range_bin == '0));
endmodule

// File: rtl/tof_range_sweep.sv
module tof_range_sweep #(
  parameter int NUM_BINS      = 500,
  parameter int SHOT_PERIOD   = 180000,
  parameter int PULSE_W       = 3,
  parameter int GATE_BASE     = 4,
  parameter int TICKS_PER_BIN = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic                        det_in,
  output logic                        laser_trig,
  output logic                        gate_strobe,
  output logic [$clog2(NUM_BINS)-1:0] range_bin,
  output logic                        no_target,
  output logic                        result_valid
);
  localparam int BIN_W = $clog2(NUM_BINS);

  logic             det_s;
  logic             running;
  logic [BIN_W-1:0] shot;
  logic             launch;
  logic             sweep_done;
  logic             sample_hit;

  tof_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(det_in), .sync_out(det_s));

  tof_shot_timer #(
    .NUM_BINS(NUM_BINS), .SHOT_PERIOD(SHOT_PERIOD), .PULSE_W(PULSE_W),
    .GATE_BASE(GATE_BASE), .TICKS_PER_BIN(TICKS_PER_BIN)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .running(running), .shot(shot),
    .launch(launch), .sweep_done(sweep_done), .laser_trig(laser_trig),
    .gate_strobe(gate_strobe));

  assign sample_hit = gate_strobe && det_s;

  tof_hit_record #(.NUM_BINS(NUM_BINS)) u_record (
    .clk(clk), .rst_n(rst_n), .clear(launch), .sample_hit(sample_hit),
    .shot(shot), .sweep_done(sweep_done), .range_bin(range_bin),
    .no_target(no_target), .result_valid(result_valid));

  assert_idle_no_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!laser_trig && !gate_strobe));

  assert_valid_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> (result_valid && !running));
endmodule

// File: tb/tb_tof_range_sweep.sv
module tb_tof_range_sweep;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 12;
  localparam int P    = 40;
  localparam int PW   = 3;
  localparam int BASE = 4;
  localparam int TPB  = 2;
  localparam int BW   = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic det_in = 1'b0;
  logic laser_trig, gate_strobe, no_target, result_valid;
  logic [BW-1:0] range_bin;

  int checks = 0, fails = 0, cycles = 0;
  int echo_lo = 0, echo_len = 0;
  bit compare_on = 1'b0;

  // reference model state
  bit m_run, m_found, m_valid, m_nt, m_s1, m_s2;
  int m_tick, m_shot, m_best, m_range;

  always #(CLK_PERIOD/2) clk = ~clk;

  tof_range_sweep #(.NUM_BINS(N), .SHOT_PERIOD(P), .PULSE_W(PW),
                    .GATE_BASE(BASE), .TICKS_PER_BIN(TPB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .det_in(det_in),
    .laser_trig(laser_trig), .gate_strobe(gate_strobe), .range_bin(range_bin),
    .no_target(no_target), .result_valid(result_valid));

  function automatic bit ref_gate(int tick, int shot);
    return tick >= BASE + shot * TPB && tick < BASE + (shot + 1) * TPB;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_run = 0; m_found = 0; m_valid = 0; m_nt = 0; m_s1 = 0; m_s2 = 0;
      m_tick = 0; m_shot = 0; m_best = 0; m_range = 0;
    end else begin
      bit hit;
      hit = m_run && ref_gate(m_tick, m_shot) && m_s2;
      m_valid = 0;
      if (m_run) begin
        if (hit && !m_found) begin m_found = 1; m_best = m_shot; end
        if (m_tick == P - 1) begin
          m_tick = 0;
          if (m_shot == N - 1) begin
            m_run = 0; m_valid = 1;
            m_range = m_found ? m_best : 0;
            m_nt = !m_found;
          end else m_shot++;
        end else m_tick++;
      end else if (start) begin
        m_run = 1; m_tick = 0; m_shot = 0; m_found = 0; m_best = 0;
      end
      m_s2 = m_s1; m_s1 = det_in;
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      check("R2 laser_trig", laser_trig, m_run && m_tick < PW);
      check("R3 gate_strobe", gate_strobe, m_run && ref_gate(m_tick, m_shot));
      check("R7 result_valid", result_valid, m_valid);
      check("R5 range_bin", range_bin, m_range);
      check("R6 no_target", no_target, m_nt);
    end
    det_in <= (echo_len < 0) ? 1'b1 :
              (m_run && m_tick >= echo_lo && m_tick < echo_lo + echo_len);
  end

  task automatic sweep(int lo, int len, int exp_bin, bit exp_nt, string tag, bit poke_again);
    int waited;
    echo_lo = lo; echo_len = len;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waited = 1;
    while (!result_valid && waited < N * P + 20) begin
      if (poke_again && waited == 100) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      waited++;
    end
    check({tag, " R7 valid latency"}, waited, N * P + 1);
    check({tag, " R5 bin"}, range_bin, exp_bin);
    check({tag, " R6 flag"}, no_target, exp_nt);
    repeat (5) @(negedge clk);
    check({tag, " R7 result held"}, range_bin, exp_bin);
    echo_len = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 laser idle", laser_trig, 0);
    check("R1 gate idle", gate_strobe, 0);
    check("R1 valid idle", result_valid, 0);
    check("R1 range idle", range_bin, 0);
    check("R1 flag idle", no_target, 0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    repeat (2) @(negedge clk);
    sweep(0, 0, 0, 1, "empty", 0);
    sweep(14, 1, 6, 0, "R4 sync delay", 0);      // seen at tick 16 -> bin 6
    sweep(24, 1, 11, 0, "farthest", 0);          // tick 26 -> bin 11
    sweep(20, 6, 9, 0, "several R5", 0);         // ticks 22..27 -> bins 9..11
    sweep(0, -1, 0, 0, "always high", 0);
    sweep(30, 4, 0, 1, "beyond gates", 0);       // ticks 32..35 -> none
    sweep(0, 2, 0, 1, "before gates", 0);        // ticks 2,3 -> none
    sweep(16, 1, 7, 0, "R8 restart ignored", 1); // tick 18 -> bin 7
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule